// File: doc/BRIEF.md
# Scoreboard Hazard Control Unit

This block is the central hazard controller for a set of functional units that share one register file. It takes decoded instructions one at a time, in program order, and hands each one to a free unit of the right class. After that it tells each unit when its operands may be read and when its result may be written back. Execution inside the units can finish in any order. The scoreboard resolves structural, RAW, WAW and WAR hazards by gating three separate handshakes: issue, operand read and write-back. It does this without moving any data itself.

Two tables hold the state. The unit status table has one entry per unit. Each entry records the destination, the two sources, the producer unit of each pending source, the per-source ready flags, and the progress flags for operands-read and execution-finished. The register result table records, for each register, whether a unit will write it and which unit that is. The default configuration has two adders, one multiplier, one divider and sixteen registers. The register file, the datapath and the units themselves sit outside this block.

Top module: `sb_scoreboard`

## Requirements
- R1: The instruction offered with `instValid` is accepted (`issueAccept` high for one cycle, `issueUnit` carrying the binary unit index) only if a unit of its class is free. The lowest-index free unit of that class is chosen. Class code 0 maps to units 0 and 1, code 1 to unit 2, and code 2 to unit 3. If the instruction is not accepted it stays at the head, and no later instruction can pass it.
- R2: Issue stalls while any busy unit already has the offered destination register. This includes a unit that is being granted write-back in that same cycle.
- R3: An instruction with class code 3 is never accepted.
- R4: `readGrant[u]` is high in every cycle in which unit u holds an instruction that has not yet read and whose two sources are both ready. All units are evaluated independently in the same cycle, and each instruction receives exactly one read grant.
- R5: A pulse on `unitDone[u]` counts only if unit u is busy and its read grant has already taken effect. Any other pulse is ignored. A counted pulse lets the unit request write-back from the following cycle.
- R6: A finished unit is not granted write-back while another busy unit has its destination as a source that is ready but not yet read.
- R7: When several finished units may write, only the lowest-index one is granted in a given cycle. The granted unit is free again in the next cycle.
- R8: On a write-back, every waiting source that names the writing unit becomes ready, so its read grant can appear in the next cycle. An instruction issued in the same cycle as that write-back also treats such a source as ready.
- R9: While reset is asserted, and in the first cycle after it, all grants are low and all units are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| instValid | input | 1 | Head instruction is present |
| instClass | input | 2 | Unit class of head instruction (0 add, 1 mul, 2 div, 3 invalid) |
| instDst | input | 4 | Destination register |
| instSrcA | input | 4 | First source register |
| instSrcB | input | 4 | Second source register |
| unitDone | input | 4 | Per-unit execution-finished pulse |
| issueAccept | output | 1 | Head instruction is issued this cycle |
| issueUnit | output | 2 | Index of the receiving unit, zero when not issuing |
| readGrant | output | 4 | Per-unit operand read grant |
| writeGrant | output | 4 | Per-unit write-back grant, at most one bit set |

## Verification
The assertions watch four things on every cycle, each against a shadow record of what was issued and granted. They check that at most one write grant is given. They check that no instruction is accepted with the invalid class code or with a destination that is still pending. They check that each unit gets only one read grant per instruction, and that it is granted write-back only after a counted done pulse. Whether a write-back is correctly held back by an unread WAR reader, or released on the right cycle, depends on the contents of the sources. So do the choice of unit, forwarding at issue, and arbitration order. These can only be shown by the bench's cycle-exact reference model as it runs the scripted hazard sequences and a long random stream.

// File: rtl/sb_pkg.sv
package sb_pkg;
  parameter int NUM_REGS = 16;
  parameter int NUM_ADD  = 2;
  parameter int NUM_MUL  = 1;
  parameter int NUM_DIV  = 1;

  localparam int NUM_UNITS = NUM_ADD + NUM_MUL + NUM_DIV;
  localparam int REG_W     = $clog2(NUM_REGS);
  localparam int UNIT_W    = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;
  localparam int CLASS_W   = 2;

  typedef enum logic [CLASS_W-1:0] {
    CLS_ADD  = 2'd0,
    CLS_MUL  = 2'd1,
    CLS_DIV  = 2'd2,
    CLS_NONE = 2'd3
  } unitClass_t;

  typedef logic [REG_W-1:0]  regIdx_t;
  typedef logic [UNIT_W-1:0] unitIdx_t;

  // one row of the unit status table
  typedef struct packed {
    logic                busy;
    logic [CLASS_W-1:0]  op;
    regIdx_t             fi;
    regIdx_t             fj;
    regIdx_t             fk;
    unitIdx_t            qj;
    unitIdx_t            qk;
    logic                qjValid;
    logic                qkValid;
    logic                rj;
    logic                rk;
    logic                readDone;
    logic                execDone;
  } fuEntry_t;

  // strobes from control to the tables
  typedef struct packed {
    logic                 issueEn;
    unitIdx_t             issueUnit;
    logic [NUM_UNITS-1:0] readEn;
    logic [NUM_UNITS-1:0] doneEn;
    logic [NUM_UNITS-1:0] writeEn;
  } sbStrobe_t;

  function automatic unitClass_t classOf(input int u);
    if (u < NUM_ADD) return CLS_ADD;
    if (u < NUM_ADD + NUM_MUL) return CLS_MUL;
    return CLS_DIV;
  endfunction
endpackage

// File: rtl/sb_tables.sv
module sb_tables
  import sb_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  sbStrobe_t          strobe,
  input  logic [CLASS_W-1:0] instClass,
  input  regIdx_t            instDst,
  input  regIdx_t            instSrcA,
  input  regIdx_t            instSrcB,
  output fuEntry_t           fuTab [NUM_UNITS],
  output logic [NUM_REGS-1:0] regBusy,
  output unitIdx_t           regOwner [NUM_REGS]
);
  logic     writeAny;
  unitIdx_t writeIdx;
  regIdx_t  wrDst;
  fuEntry_t newEnt;
  logic     fwdA, fwdB;

  assign writeAny = |strobe.writeEn;

  always_comb begin
    writeIdx = '0;
    for (int u = 0; u < NUM_UNITS; u++)
      if (strobe.writeEn[u]) writeIdx = unitIdx_t'(u);
  end

  assign wrDst = fuTab[writeIdx].fi;
  assign fwdA  = writeAny && (regOwner[instSrcA] == writeIdx);
  assign fwdB  = writeAny && (regOwner[instSrcB] == writeIdx);

  always_comb begin
    newEnt          = '0;
    newEnt.busy     = 1'b1;
    newEnt.op       = instClass;
    newEnt.fi       = instDst;
    newEnt.fj       = instSrcA;
    newEnt.fk       = instSrcB;
    newEnt.qj       = regOwner[instSrcA];
    newEnt.qk       = regOwner[instSrcB];
    newEnt.qjValid  = regBusy[instSrcA] && !fwdA;
    newEnt.qkValid  = regBusy[instSrcB] && !fwdB;
    newEnt.rj       = !newEnt.qjValid;
    newEnt.rk       = !newEnt.qkValid;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int u = 0; u < NUM_UNITS; u++) fuTab[u] <= '0;
      for (int r = 0; r < NUM_REGS; r++) begin
        regBusy[r]  <= 1'b0;
        regOwner[r] <= '0;
      end
    end else begin
      for (int u = 0; u < NUM_UNITS; u++) begin
        if (strobe.writeEn[u]) begin
          fuTab[u] <= '0;
        end else if (strobe.issueEn && strobe.issueUnit == unitIdx_t'(u)) begin
          fuTab[u] <= newEnt;
        end else begin
          if (strobe.doneEn[u]) fuTab[u].execDone <= 1'b1;
          if (strobe.readEn[u]) begin
            fuTab[u].readDone <= 1'b1;
            fuTab[u].rj       <= 1'b0;
            fuTab[u].rk       <= 1'b0;
          end
          if (writeAny && fuTab[u].qjValid && fuTab[u].qj == writeIdx) begin
            fuTab[u].rj      <= 1'b1;
            fuTab[u].qjValid <= 1'b0;
          end
          if (writeAny && fuTab[u].qkValid && fuTab[u].qk == writeIdx) begin
            fuTab[u].rk      <= 1'b1;
            fuTab[u].qkValid <= 1'b0;
          end
        end
      end
      for (int r = 0; r < NUM_REGS; r++) begin
        if (writeAny && wrDst == regIdx_t'(r)) regBusy[r] <= 1'b0;
        if (strobe.issueEn && instDst == regIdx_t'(r)) begin
          regBusy[r]  <= 1'b1;
          regOwner[r] <= strobe.issueUnit;
        end
      end
    end
  end
endmodule

// File: rtl/sb_control.sv
module sb_control
  import sb_pkg::*;
(
  input  fuEntry_t             fuTab [NUM_UNITS],
  input  logic [NUM_REGS-1:0]  regBusy,
  input  logic                 instValid,
  input  logic [CLASS_W-1:0]   instClass,
  input  regIdx_t              instDst,
  input  logic [NUM_UNITS-1:0] unitDone,
  output sbStrobe_t            strobe
);
  logic                 found;
  unitIdx_t             pick;
  logic                 classOk;
  logic [NUM_UNITS-1:0] warBlock;
  logic [NUM_UNITS-1:0] writeReq;

  assign classOk = (unitClass_t'(instClass) != CLS_NONE);

  // lowest-index free unit of the requested class
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int u = NUM_UNITS - 1; u >= 0; u--) begin
      if (!fuTab[u].busy && classOf(u) == unitClass_t'(instClass)) begin
        found = 1'b1;
        pick  = unitIdx_t'(u);
      end
    end
  end

  // a reader still holding the old value of unit u's destination
  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++) begin
      warBlock[u] = 1'b0;
      for (int v = 0; v < NUM_UNITS; v++) begin
        if (v != u && fuTab[v].busy &&
            ((fuTab[v].rj && fuTab[v].fj == fuTab[u].fi) ||
             (fuTab[v].rk && fuTab[v].fk == fuTab[u].fi)))
          warBlock[u] = 1'b1;
      end
    end
  end

  always_comb begin
    for (int u = 0; u < NUM_UNITS; u++) begin
      writeReq[u]      = fuTab[u].busy && fuTab[u].execDone && !warBlock[u];
      strobe.readEn[u] = fuTab[u].busy && !fuTab[u].readDone && fuTab[u].rj && fuTab[u].rk;
      strobe.doneEn[u] = unitDone[u] && fuTab[u].busy && fuTab[u].readDone && !fuTab[u].execDone;
    end
    strobe.writeEn   = writeReq & (~writeReq + 1'b1);
    strobe.issueEn   = instValid && classOk && found && !regBusy[instDst];
    strobe.issueUnit = strobe.issueEn ? pick : '0;
  end
endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard
  import sb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 instValid,
  input  logic [CLASS_W-1:0]   instClass,
  input  logic [REG_W-1:0]     instDst,
  input  logic [REG_W-1:0]     instSrcA,
  input  logic [REG_W-1:0]     instSrcB,
  input  logic [NUM_UNITS-1:0] unitDone,
  output logic                 issueAccept,
  output logic [UNIT_W-1:0]    issueUnit,
  output logic [NUM_UNITS-1:0] readGrant,
  output logic [NUM_UNITS-1:0] writeGrant
);
  sbStrobe_t           strobe;
  fuEntry_t            fuTab [NUM_UNITS];
  logic [NUM_REGS-1:0] regBusy;
  unitIdx_t            regOwner [NUM_REGS];

  sb_control uCtrl (
    .fuTab     (fuTab),
    .regBusy   (regBusy),
    .instValid (instValid),
    .instClass (instClass),
    .instDst   (instDst),
    .unitDone  (unitDone),
    .strobe    (strobe)
  );

  sb_tables uTab (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .instClass (instClass),
    .instDst   (instDst),
    .instSrcA  (instSrcA),
    .instSrcB  (instSrcB),
    .fuTab     (fuTab),
    .regBusy   (regBusy),
    .regOwner  (regOwner)
  );

  assign issueAccept = strobe.issueEn;
  assign issueUnit   = strobe.issueUnit;
  assign readGrant   = strobe.readEn;
  assign writeGrant  = strobe.writeEn;
endmodule

// File: rtl/sb_checker.sv
module sb_checker
  import sb_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic                 instValid,
  input logic [CLASS_W-1:0]   instClass,
  input logic [REG_W-1:0]     instDst,
  input logic                 issueAccept,
  input logic [UNIT_W-1:0]    issueUnit,
  input logic [NUM_UNITS-1:0] readGrant,
  input logic [NUM_UNITS-1:0] writeGrant,
  input logic [NUM_UNITS-1:0] unitDone
);
  logic [NUM_REGS-1:0]  pendReg;
  logic [REG_W-1:0]     dstOf [NUM_UNITS];
  logic [NUM_UNITS-1:0] readSeen;
  logic [NUM_UNITS-1:0] doneSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendReg  <= '0;
      readSeen <= '0;
      doneSeen <= '0;
      for (int u = 0; u < NUM_UNITS; u++) dstOf[u] <= '0;
    end else begin
      for (int u = 0; u < NUM_UNITS; u++) begin
        if (writeGrant[u]) begin
          pendReg[dstOf[u]] <= 1'b0;
          readSeen[u]       <= 1'b0;
          doneSeen[u]       <= 1'b0;
        end else begin
          if (readGrant[u]) readSeen[u] <= 1'b1;
          if (unitDone[u] && readSeen[u]) doneSeen[u] <= 1'b1;
        end
      end
      if (issueAccept) begin
        pendReg[instDst]  <= 1'b1;
        dstOf[issueUnit]  <= instDst;
      end
    end
  end

  AST_WRITE_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) $onehot0(writeGrant)); // R7
  AST_NO_BAD_CLASS: assert property (@(posedge clk) disable iff (!rstN) issueAccept |-> (instValid && instClass != 2'd3)); // R3
  AST_NO_WAW_ISSUE: assert property (@(posedge clk) disable iff (!rstN) issueAccept |-> !pendReg[instDst]); // R2

  for (genvar g = 0; g < NUM_UNITS; g++) begin : gUnitChk
    AST_WRITE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rstN) writeGrant[g] |-> doneSeen[g]); // R5
    AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rstN) readGrant[g] |-> !readSeen[g]); // R4
  end
endmodule

bind sb_scoreboard sb_checker uChk (
  .clk         (clk),
  .rstN        (rstN),
  .instValid   (instValid),
  .instClass   (instClass),
  .instDst     (instDst),
  .issueAccept (issueAccept),
  .issueUnit   (issueUnit),
  .readGrant   (readGrant),
  .writeGrant  (writeGrant),
  .unitDone    (unitDone)
);

// File: tb/sim_sb_scoreboard.sv
module sim_sb_scoreboard;
  import sb_pkg::*;
  localparam int NU = NUM_UNITS;
  localparam int NR = NUM_REGS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic                 instValid = 1'b0;
  logic [CLASS_W-1:0]   instClass = '0;
  logic [REG_W-1:0]     instDst = '0, instSrcA = '0, instSrcB = '0;
  logic [NU-1:0]        unitDone = '0;
  logic                 issueAccept;
  logic [UNIT_W-1:0]    issueUnit;
  logic [NU-1:0]        readGrant, writeGrant;

  sb_scoreboard u0 (
    .clk(clk), .rstN(rstN), .instValid(instValid), .instClass(instClass),
    .instDst(instDst), .instSrcA(instSrcA), .instSrcB(instSrcB),
    .unitDone(unitDone), .issueAccept(issueAccept), .issueUnit(issueUnit),
    .readGrant(readGrant), .writeGrant(writeGrant)
  );

  typedef struct { int c; int d; int a; int b; } ins_t;
  ins_t prog[$];

  int nChecks = 0, nFails = 0, cyc = 0;
  int unitCls[NU] = '{0, 0, 1, 2};
  int lat[NU]     = '{2, 2, 6, 10};
  int cnt[NU];
  logic [NU-1:0] spur = '0;
  int spurRecent = 0;
  int gapPct = 0;

  // reference model state
  int mBusy[NU], mFi[NU], mFj[NU], mFk[NU], mQj[NU], mQk[NU];
  int mRj[NU], mRk[NU], mRead[NU], mDone[NU], mFwd[NU];
  int regOwn[NR];
  int covStruct = 0, covWaw = 0, covCls = 0, covWar = 0, covDual = 0, covFwd = 0, covSpur = 0;

  task automatic check(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic modelReset();
    for (int u = 0; u < NU; u++) begin
      mBusy[u] = 0; mQj[u] = -1; mQk[u] = -1; mRj[u] = 0; mRk[u] = 0;
      mRead[u] = 0; mDone[u] = 0; mFwd[u] = 0; cnt[u] = 0;
      mFi[u] = 0; mFj[u] = 0; mFk[u] = 0;
    end
    for (int r = 0; r < NR; r++) regOwn[r] = -1;
  endtask

  function automatic int anyBusy();
    for (int u = 0; u < NU; u++) if (mBusy[u] != 0) return 1;
    return 0;
  endfunction

  task automatic cycle();
    int w, nreq, warAny, expIss, expUnit, expRead, expWrite, fwdRead, v;
    string itag;
    ins_t h;
    bit gap;
    @(negedge clk);
    cyc++;
    gap = ($urandom_range(99) < gapPct);
    if (prog.size() > 0 && !gap) begin
      h = prog[0];
      instValid = 1'b1; instClass = h.c[CLASS_W-1:0]; instDst = h.d[REG_W-1:0];
      instSrcA = h.a[REG_W-1:0]; instSrcB = h.b[REG_W-1:0];
    end else begin
      instValid = 1'b0;
    end
    for (int u = 0; u < NU; u++) unitDone[u] = (cnt[u] == 1) || spur[u];
    if (spur != 0) spurRecent = 4; else if (spurRecent > 0) spurRecent--;
    #2;
    // expected write-back
    w = -1; nreq = 0; warAny = 0;
    for (int u = 0; u < NU; u++) begin
      int blk = 0;
      for (int x = 0; x < NU; x++)
        if (x != u && mBusy[x] != 0 &&
            ((mRj[x] != 0 && mFj[x] == mFi[u]) || (mRk[x] != 0 && mFk[x] == mFi[u]))) blk = 1;
      if (mBusy[u] != 0 && mDone[u] != 0) begin
        if (blk != 0) begin warAny = 1; covWar++; end
        else begin nreq++; if (w < 0) w = u; end
      end
    end
    if (nreq > 1) covDual++;
    expWrite = (w >= 0) ? (1 << w) : 0;
    // expected reads
    expRead = 0; fwdRead = 0;
    for (int u = 0; u < NU; u++)
      if (mBusy[u] != 0 && mRead[u] == 0 && mRj[u] != 0 && mRk[u] != 0) begin
        expRead |= (1 << u);
        if (mFwd[u] != 0) begin fwdRead = 1; covFwd++; end
      end
    // expected issue
    expIss = 0; expUnit = 0; itag = "R1";
    if (instValid) begin
      v = -1;
      for (int u = NU - 1; u >= 0; u--) if (mBusy[u] == 0 && unitCls[u] == int'(instClass)) v = u;
      if (instClass == 2'd3) begin itag = "R3"; covCls++; end
      else if (regOwn[instDst] >= 0) begin itag = "R2"; covWaw++; end
      else if (v < 0) begin itag = "R1"; covStruct++; end
      else begin expIss = 1; expUnit = v; end
    end
    check(itag, int'(issueAccept), expIss);
    if (expIss != 0) check("R1", int'(issueUnit), expUnit);
    check(fwdRead ? "R8" : "R4", int'(readGrant), expRead);
    check(spurRecent > 0 ? "R5" : (warAny ? "R6" : "R7"), int'(writeGrant), expWrite);
    if (spur != 0) covSpur++;
    // model next state: done, read, write, then issue
    for (int u = 0; u < NU; u++)
      if (unitDone[u] && mBusy[u] != 0 && mRead[u] != 0) mDone[u] = 1;
    for (int u = 0; u < NU; u++)
      if (expRead[u]) begin mRead[u] = 1; mRj[u] = 0; mRk[u] = 0; mFwd[u] = 0; end
    if (w >= 0) begin
      mBusy[w] = 0; mRead[w] = 0; mDone[w] = 0; mRj[w] = 0; mRk[w] = 0;
      mQj[w] = -1; mQk[w] = -1; mFwd[w] = 0;
      regOwn[mFi[w]] = -1;
      for (int u = 0; u < NU; u++) if (mBusy[u] != 0) begin
        if (mQj[u] == w) begin mQj[u] = -1; mRj[u] = 1; mFwd[u] = 1; end
        if (mQk[u] == w) begin mQk[u] = -1; mRk[u] = 1; mFwd[u] = 1; end
      end
    end
    if (expIss != 0) begin
      mBusy[expUnit] = 1; mFi[expUnit] = h.d; mFj[expUnit] = h.a; mFk[expUnit] = h.b;
      mQj[expUnit] = regOwn[h.a]; mQk[expUnit] = regOwn[h.b];
      mRj[expUnit] = (mQj[expUnit] < 0); mRk[expUnit] = (mQk[expUnit] < 0);
      mRead[expUnit] = 0; mDone[expUnit] = 0; mFwd[expUnit] = 0;
      regOwn[h.d] = expUnit;
      void'(prog.pop_front());
    end
    // stub units
    for (int u = 0; u < NU; u++) begin
      if (cnt[u] == 1) cnt[u] = 0;
      else if (cnt[u] > 0) cnt[u]--;
      if (expRead[u]) cnt[u] = lat[u];
    end
  endtask

  task automatic runIdle();
    int guard = 0;
    while ((prog.size() > 0 || anyBusy() != 0) && guard < 20000) begin
      cycle();
      guard++;
    end
  endtask

  task automatic push(int c, int d, int a, int b);
    ins_t t;
    t.c = c; t.d = d; t.a = a; t.b = b;
    prog.push_back(t);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual hung expected finished (cycle %0d)", cyc);
    summary();
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    // R9: outputs idle during reset
    check("R9", int'(issueAccept), 0);
    check("R9", int'(readGrant), 0);
    check("R9", int'(writeGrant), 0);
    rstN = 1'b1;
    cycle();
    // classic hazard sequence: RAW chain, WAR hold, structural and WAW stalls
    push(1, 1, 2, 3);
    push(0, 4, 1, 5);
    push(2, 6, 4, 7);
    push(0, 7, 8, 9);
    push(0, 9, 1, 1);
    push(1, 4, 10, 11);
    push(0, 2, 7, 6);
    runIdle();
    // R3: invalid class never issues
    push(3, 5, 0, 0);
    repeat (6) cycle();
    prog.delete();
    // R5: done pulses on idle units and on a unit that has not yet read
    spur = 4'b1100;
    cycle();
    spur = '0;
    push(2, 3, 4, 5);
    cycle();
    spur = 4'b1000;
    cycle();
    spur = '0;
    runIdle();
    // R7 and R8: two readers released together by one write, then colliding
    push(1, 2, 3, 3);
    push(0, 4, 2, 5);
    push(0, 6, 2, 7);
    runIdle();
    // random stream with bubbles
    gapPct = 25;
    for (int i = 0; i < 400; i++)
      push($urandom_range(2), $urandom_range(NR - 1), $urandom_range(NR - 1), $urandom_range(NR - 1));
    runIdle();
    gapPct = 0;
    repeat (3) cycle();
    // scenario coverage
    check("R1", int'(covStruct > 0), 1);
    check("R2", int'(covWaw > 0), 1);
    check("R3", int'(covCls > 0), 1);
    check("R5", int'(covSpur > 0), 1);
    check("R6", int'(covWar > 0), 1);
    check("R7", int'(covDual > 0), 1);
    check("R8", int'(covFwd > 0), 1);
    check("R4", int'(prog.size()), 0);
    summary();
  end
endmodule